// File: doc/BRIEF.md
# Descriptor Chain Packet Length Checker

This block sits beside a system-to-card DMA engine and watches the descriptors the engine takes on. Each descriptor carries a control byte count, the capacity of its buffer and an end-of-packet flag. The block checks every descriptor against the fill rules. It adds the control counts of a chain until the end-of-packet descriptor arrives, then reports the packet length once, together with error and overflow indications for the whole packet.

One descriptor is in flight at a time. The engine hands a descriptor over on a valid/ready handshake. When that descriptor's transfer finishes, the engine presents the number of bytes it actually moved. The block turns that number into a status write-back value. It raises a sticky mismatch flag when the moved count differs from the control count. The flag lasts until the next packet begins.

Top module: `desc_pkt_len_chk`

## Requirements
- R1: After reset, desc_ready is 1 and wb_valid, desc_err, pkt_len_valid, pkt_ovf, pkt_err and cnt_mismatch are all 0.
- R2: A descriptor accepted with desc_eop = 0 whose control count differs from its capacity gives a one-cycle desc_err pulse in the cycle after acceptance. A count equal to the capacity gives no pulse.
- R3: A descriptor accepted with desc_eop = 1 whose control count lies in 1..capacity gives no desc_err.
- R4: A control count of zero, or one larger than the capacity, gives desc_err whatever desc_eop is.
- R5: In the cycle after the end-of-packet descriptor is accepted, pkt_len_valid is 1 for exactly one cycle. pkt_len then equals the sum of the control counts of all descriptors of the packet, including that last one. The next descriptor starts a new sum from zero.
- R6: When the sum of a packet exceeds 2^LEN_W-1, pkt_len reads all ones and pkt_ovf is 1 alongside pkt_len_valid. The next packet reports pkt_ovf = 0 unless it overflows itself.
- R7: pkt_err is 1 alongside pkt_len_valid exactly when at least one descriptor of that packet raised desc_err.
- R8: After a descriptor is accepted, desc_ready stays 0 until a completion arrives. A descriptor offered while desc_ready is 0 is not taken and adds nothing to the packet length.
- R9: A cmpl_valid while a descriptor is in flight gives wb_valid = 1 in the next cycle, with wb_cnt equal to cmpl_cnt. A cmpl_valid with no descriptor in flight is ignored: no wb_valid, and desc_ready stays 1.
- R10: A completion count that differs from the descriptor's control count sets cnt_mismatch. The flag stays set until the first descriptor of the next packet is accepted, and is cleared in the cycle after that acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Block can take a descriptor (none in flight) |
| desc_ctl_cnt | input | 20 | Control byte count written into the descriptor |
| desc_cap | input | 20 | Buffer capacity of the descriptor in bytes |
| desc_eop | input | 1 | Descriptor ends the packet |
| cmpl_valid | input | 1 | Transfer of the in-flight descriptor finished |
| cmpl_cnt | input | 20 | Bytes actually moved for that descriptor |
| wb_valid | output | 1 | Status write-back value present |
| wb_cnt | output | 20 | Status byte count to write back |
| desc_err | output | 1 | Fill-rule violation of the last accepted descriptor |
| pkt_len_valid | output | 1 | Packet length present (one cycle) |
| pkt_len | output | 32 | Total packet length in bytes |
| pkt_ovf | output | 1 | Packet length sum overflowed |
| pkt_err | output | 1 | Some descriptor of the packet broke a fill rule |
| cnt_mismatch | output | 1 | Sticky moved-count mismatch for the current packet |

## Verification
The length sum is tried with a two-descriptor chain, with one-descriptor packets, and with a chain whose first entry is at the 20-bit maximum. Together these separate a correct running sum from one that drops a term, fails to restart, or truncates to 20 bits. The fill rules are tried with a short non-final entry, a zero count and an over-capacity count, so that each violation class is seen on its own. A chain of more than four thousand full descriptors drives the sum past 32 bits and shows saturation, and the packet after it shows that the overflow indication clears. Offers made during a busy cycle, completions with nothing in flight, and a mismatching completion followed by a new packet show the handshake and the lifetime of the sticky flag.

// File: rtl/dplc_pkg.sv
package dplc_pkg;

  typedef enum logic [1:0] {
    RULE_OK       = 2'd0,
    RULE_ZERO     = 2'd1,
    RULE_OVER_CAP = 2'd2,
    RULE_SHORT    = 2'd3
  } rule_e;

endpackage

// File: rtl/dplc_rule_chk.sv
module dplc_rule_chk
  import dplc_pkg::*;
#(
  parameter int CNT_W = 20
) (
  input  logic [CNT_W-1:0] ctl_cnt,
  input  logic [CNT_W-1:0] cap,
  input  logic             eop,
  output rule_e            cause,
  output logic             bad
);

  // zero first, then over capacity, then a partly filled non-final entry
  always_comb begin
    if (ctl_cnt == '0)
      cause = RULE_ZERO;
    else if (ctl_cnt > cap)
      cause = RULE_OVER_CAP;
    else if (!eop && (ctl_cnt != cap))
      cause = RULE_SHORT;
    else
      cause = RULE_OK;
  end

  assign bad = (cause != RULE_OK);

  always_comb begin
    if (eop && (ctl_cnt != '0) && (ctl_cnt <= cap))
      assert (!bad) else $error("AST_EOP_PARTIAL_OK"); // R3
  end

endmodule

// File: rtl/dplc_len_acc.sv
module dplc_len_acc #(
  parameter int CNT_W      = 20,
  parameter int LEN_W      = 32,
  parameter bit SAT_ON_OVF = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             add_en,
  input  logic [CNT_W-1:0] cnt,
  input  logic             last,
  input  logic             rule_bad,
  output logic             first,
  output logic             len_valid,
  output logic [LEN_W-1:0] len,
  output logic             len_ovf,
  output logic             len_err
);

  localparam int PAD_W = LEN_W + 1 - CNT_W;

  logic [LEN_W-1:0] acc_q;
  logic             ovf_q;
  logic             err_q;
  logic             first_q;
  logic [LEN_W:0]   sum_w;
  logic             ovf_now;
  logic [LEN_W-1:0] nxt_w;

  assign sum_w   = {1'b0, acc_q} + {{PAD_W{1'b0}}, cnt};
  assign ovf_now = ovf_q | sum_w[LEN_W];

  generate
    if (SAT_ON_OVF) begin : g_sat
      assign nxt_w = ovf_now ? {LEN_W{1'b1}} : sum_w[LEN_W-1:0];
    end else begin : g_wrap
      assign nxt_w = sum_w[LEN_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q     <= '0;
      ovf_q     <= 1'b0;
      err_q     <= 1'b0;
      first_q   <= 1'b1;
      len_valid <= 1'b0;
      len       <= '0;
      len_ovf   <= 1'b0;
      len_err   <= 1'b0;
    end else begin
      len_valid <= 1'b0;
      if (add_en) begin
        if (last) begin
          len_valid <= 1'b1;
          len       <= nxt_w;
          len_ovf   <= ovf_now;
          len_err   <= err_q | rule_bad;
          acc_q     <= '0;
          ovf_q     <= 1'b0;
          err_q     <= 1'b0;
          first_q   <= 1'b1;
        end else begin
          acc_q     <= nxt_w;
          ovf_q     <= ovf_now;
          err_q     <= err_q | rule_bad;
          first_q   <= 1'b0;
        end
      end
    end
  end

  assign first = first_q;

  AST_ACC_NEVER_DROPS: assert property (@(posedge clk) disable iff (rst)
    (add_en && !last && SAT_ON_OVF) |=> (acc_q >= $past(acc_q))); // R5

  AST_NEW_PKT_FROM_ZERO: assert property (@(posedge clk) disable iff (rst)
    (add_en && last) |=> (acc_q == '0 && !ovf_q && !err_q)); // R5

endmodule

// File: rtl/dplc_status_wb.sv
module dplc_status_wb #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic [CNT_W-1:0] take_cnt,
  input  logic             pkt_start,
  input  logic             done,
  input  logic [CNT_W-1:0] done_cnt,
  output logic             busy,
  output logic             wb_v,
  output logic [CNT_W-1:0] wb_c,
  output logic             mism
);

  logic [CNT_W-1:0] ctl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      ctl_q <= '0;
      wb_v  <= 1'b0;
      wb_c  <= '0;
      mism  <= 1'b0;
    end else begin
      wb_v <= 1'b0;
      if (take) begin
        busy  <= 1'b1;
        ctl_q <= take_cnt;
        if (pkt_start)
          mism <= 1'b0;
      end else if (done && busy) begin
        busy <= 1'b0;
        wb_v <= 1'b1;
        wb_c <= done_cnt;
        if (done_cnt != ctl_q)
          mism <= 1'b1;
      end
    end
  end

  AST_MISMATCH_STICKY: assert property (@(posedge clk) disable iff (rst)
    (mism && !(take && pkt_start)) |=> mism); // R10

  AST_NO_TAKE_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |-> !take); // R8

endmodule

// File: rtl/desc_pkt_len_chk.sv
module desc_pkt_len_chk
  import dplc_pkg::*;
#(
  parameter int CNT_W      = 20,
  parameter int LEN_W      = 32,
  parameter bit SAT_ON_OVF = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             desc_valid,
  output logic             desc_ready,
  input  logic [CNT_W-1:0] desc_ctl_cnt,
  input  logic [CNT_W-1:0] desc_cap,
  input  logic             desc_eop,
  input  logic             cmpl_valid,
  input  logic [CNT_W-1:0] cmpl_cnt,
  output logic             wb_valid,
  output logic [CNT_W-1:0] wb_cnt,
  output logic             desc_err,
  output logic             pkt_len_valid,
  output logic [LEN_W-1:0] pkt_len,
  output logic             pkt_ovf,
  output logic             pkt_err,
  output logic             cnt_mismatch
);

  logic  accept;
  logic  busy;
  logic  rule_bad;
  logic  pkt_first;
  rule_e rule_cause;

  assign desc_ready = !busy;
  assign accept     = desc_valid && desc_ready;

  dplc_rule_chk #(.CNT_W(CNT_W)) u_rule (
    .ctl_cnt (desc_ctl_cnt),
    .cap     (desc_cap),
    .eop     (desc_eop),
    .cause   (rule_cause),
    .bad     (rule_bad)
  );

  dplc_len_acc #(.CNT_W(CNT_W), .LEN_W(LEN_W), .SAT_ON_OVF(SAT_ON_OVF)) u_acc (
    .clk       (clk),
    .rst       (rst),
    .add_en    (accept),
    .cnt       (desc_ctl_cnt),
    .last      (desc_eop),
    .rule_bad  (rule_bad),
    .first     (pkt_first),
    .len_valid (pkt_len_valid),
    .len       (pkt_len),
    .len_ovf   (pkt_ovf),
    .len_err   (pkt_err)
  );

  dplc_status_wb #(.CNT_W(CNT_W)) u_stat (
    .clk       (clk),
    .rst       (rst),
    .take      (accept),
    .take_cnt  (desc_ctl_cnt),
    .pkt_start (pkt_first),
    .done      (cmpl_valid),
    .done_cnt  (cmpl_cnt),
    .busy      (busy),
    .wb_v      (wb_valid),
    .wb_c      (wb_cnt),
    .mism      (cnt_mismatch)
  );

  always_ff @(posedge clk) begin
    if (rst)
      desc_err <= 1'b0;
    else
      desc_err <= accept && rule_bad;
  end

  AST_READY_DROPS: assert property (@(posedge clk) disable iff (rst)
    (desc_valid && desc_ready) |=> !desc_ready); // R8

  AST_ERR_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    desc_err |-> $past(desc_valid && desc_ready)); // R2

  AST_WB_NEEDS_CMPL: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> $past(cmpl_valid && !desc_ready)); // R9

  AST_LEN_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    pkt_len_valid |=> !pkt_len_valid); // R5

  AST_OVF_SATURATES: assert property (@(posedge clk) disable iff (rst)
    (pkt_len_valid && pkt_ovf && SAT_ON_OVF) |-> (pkt_len == {LEN_W{1'b1}})); // R6

endmodule

// File: tb/desc_pkt_len_chk_tb.sv
`timescale 1ns/1ps
module desc_pkt_len_chk_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        desc_valid = 1'b0;
  logic        desc_ready;
  logic [19:0] desc_ctl_cnt = '0;
  logic [19:0] desc_cap = '0;
  logic        desc_eop = 1'b0;
  logic        cmpl_valid = 1'b0;
  logic [19:0] cmpl_cnt = '0;
  logic        wb_valid;
  logic [19:0] wb_cnt;
  logic        desc_err;
  logic        pkt_len_valid;
  logic [31:0] pkt_len;
  logic        pkt_ovf;
  logic        pkt_err;
  logic        cnt_mismatch;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  desc_pkt_len_chk u_dut (
    .clk(clk), .rst(rst),
    .desc_valid(desc_valid), .desc_ready(desc_ready),
    .desc_ctl_cnt(desc_ctl_cnt), .desc_cap(desc_cap), .desc_eop(desc_eop),
    .cmpl_valid(cmpl_valid), .cmpl_cnt(cmpl_cnt),
    .wb_valid(wb_valid), .wb_cnt(wb_cnt), .desc_err(desc_err),
    .pkt_len_valid(pkt_len_valid), .pkt_len(pkt_len), .pkt_ovf(pkt_ovf),
    .pkt_err(pkt_err), .cnt_mismatch(cnt_mismatch)
  );

  localparam int NV = 8;
  localparam logic [19:0] V_CTL [NV] = '{20'd100, 20'd50, 20'd64, 20'd10, 20'd0,  20'd30, 20'hFFFFF, 20'd1};
  localparam logic [19:0] V_CAP [NV] = '{20'd100, 20'd100, 20'd64, 20'd20, 20'd8, 20'd20, 20'hFFFFF, 20'hFFFFF};
  localparam logic        V_EOP [NV] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1};
  localparam logic [19:0] V_CMP [NV] = '{20'd100, 20'd50, 20'd60, 20'd10, 20'd0, 20'd30, 20'hFFFFF, 20'd1};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic send(input logic [19:0] c, input logic [19:0] k, input logic e);
    desc_ctl_cnt = c;
    desc_cap     = k;
    desc_eop     = e;
    desc_valid   = 1'b1;
    @(negedge clk);
    desc_valid   = 1'b0;
  endtask

  task automatic complete(input logic [19:0] n);
    cmpl_cnt   = n;
    cmpl_valid = 1'b1;
    @(negedge clk);
    cmpl_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] acc;
    logic        perr;
    logic        mism;
    logic        first;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 desc_ready", 32'(desc_ready), 32'd1);
    chk("R1 quiet outputs", {26'd0, wb_valid, desc_err, pkt_len_valid, pkt_ovf, pkt_err, cnt_mismatch}, 32'd0);

    // table walk
    acc = 0; perr = 0; mism = 0; first = 1;
    for (int i = 0; i < NV; i++) begin
      logic ex_err;
      ex_err = (V_CTL[i] == 0) || (V_CTL[i] > V_CAP[i]) || (!V_EOP[i] && V_CTL[i] != V_CAP[i]);
      chk("R8 ready before offer", 32'(desc_ready), 32'd1);
      send(V_CTL[i], V_CAP[i], V_EOP[i]);
      if (first) mism = 0;
      first = V_EOP[i];
      acc   = acc + 32'(V_CTL[i]);
      perr  = perr | ex_err;
      chk("R2 R3 R4 desc_err", 32'(desc_err), 32'(ex_err));
      chk("R8 ready low in flight", 32'(desc_ready), 32'd0);
      chk("R10 mismatch after accept", 32'(cnt_mismatch), 32'(mism));
      chk("R5 pkt_len_valid", 32'(pkt_len_valid), 32'(V_EOP[i]));
      if (V_EOP[i]) begin
        chk("R5 pkt_len", pkt_len, acc);
        chk("R7 pkt_err", 32'(pkt_err), 32'(perr));
        chk("R6 pkt_ovf clear", 32'(pkt_ovf), 32'd0);
        acc = 0; perr = 0;
      end
      complete(V_CMP[i]);
      if (V_CMP[i] != V_CTL[i]) mism = 1;
      chk("R9 wb_valid", 32'(wb_valid), 32'd1);
      chk("R9 wb_cnt", 32'(wb_cnt), 32'(V_CMP[i]));
      chk("R10 mismatch after completion", 32'(cnt_mismatch), 32'(mism));
      chk("R5 length pulse one cycle", 32'(pkt_len_valid), 32'd0);
    end

    // R9: completion with nothing in flight is ignored
    complete(20'd77);
    chk("R9 idle completion no wb", 32'(wb_valid), 32'd0);
    chk("R9 idle completion ready", 32'(desc_ready), 32'd1);

    // R8: offer during busy is not taken
    send(20'd40, 20'd40, 1'b0);
    send(20'd7, 20'd7, 1'b1);
    chk("R8 busy offer ignored no length", 32'(pkt_len_valid), 32'd0);
    chk("R8 busy offer no err", 32'(desc_err), 32'd0);
    complete(20'd40);
    send(20'd5, 20'd9, 1'b1);
    chk("R8 busy offer excluded from length", pkt_len, 32'd45);
    chk("R3 partial eop ok", 32'(desc_err), 32'd0);
    complete(20'd5);

    // R6: overflow of the 32-bit sum saturates
    for (int j = 0; j < 4097; j++) begin
      send(20'hFFFFF, 20'hFFFFF, 1'b0);
      complete(20'hFFFFF);
    end
    send(20'd1, 20'd1, 1'b1);
    chk("R6 overflow valid", 32'(pkt_len_valid), 32'd1);
    chk("R6 overflow saturated", pkt_len, 32'hFFFFFFFF);
    chk("R6 overflow flag", 32'(pkt_ovf), 32'd1);
    complete(20'd1);
    send(20'd3, 20'd3, 1'b1);
    chk("R6 next packet length", pkt_len, 32'd3);
    chk("R6 next packet no ovf", 32'(pkt_ovf), 32'd0);
    complete(20'd3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule